// File: doc/BRIEF.md
# Interlocked Handshake Memory Slave

This block is a memory target that answers a clockless, fully interlocked request/acknowledge bus. A master places an address (and, for a store, the data) on the bus and then raises either a read strobe or a write strobe. There is no fixed transfer length. The slave brings both strobes into its own clock through flop chains and latches the address and data. After a configurable number of wait cycles it performs the access against a bank of internal registers and raises acknowledge. It holds acknowledge until the master withdraws its strobe. On a read it also drives the data, with an output enable, before acknowledge rises, and it removes both when the strobe goes away.

Having the two strobes separate gives three legal bus states: read, write and free, which is both strobes low. The slave treats both strobes high together as a protocol error. It never acknowledges that case, never writes during it, and leaves the error only once the bus is free. Acknowledge always falls and stays low for at least one cycle before the next command is taken. The wait-cycle parameter stands in for a slow storage array.

Top module: `hs_mem_slave`

## Requirements
- R1: After reset, bus_ack and bus_rdata_oe are 0, bus_rdata is 0, and every storage word reads back as 0.
- R2: A write stores bus_wdata at word bus_addr. Acknowledge is seen high WAIT_CYC+4 clock cycles after the cycle in which bus_wr is raised, which is after the store has been made.
- R3: A read drives the stored word on bus_rdata with bus_rdata_oe high WAIT_CYC+4 cycles after bus_rd rises. Acknowledge follows one cycle later, at WAIT_CYC+5, so the data is stable before acknowledge.
- R4: Acknowledge (and, on a read, the data and output enable) stays high for as long as the master holds its strobe. It falls exactly 3 cycles after the strobe is removed.
- R5: Whenever bus_rdata_oe is low, bus_rdata is 0. The output enable is never high during a write.
- R6: If bus_rd and bus_wr are both high, the slave gives no acknowledge and stores nothing. It stays in this error condition until both strobes are low.
- R7: A new command is taken only after acknowledge has gone low. When a strobe is swapped for the other one in the same cycle, acknowledge is low 3 cycles later and the new command is acknowledged WAIT_CYC+5 cycles after the swap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock of the slave |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Word address, stable before a strobe rises |
| bus_wdata | input | DATA_W | Write data, presented together with the address |
| bus_rdata | output | DATA_W | Read data, zero when not driven |
| bus_rdata_oe | output | 1 | High while the slave drives bus_rdata |
| bus_rd | input | 1 | Read command strobe, asynchronous |
| bus_wr | input | 1 | Write command strobe, asynchronous |
| bus_ack | output | 1 | Acknowledge, held until the strobe is withdrawn |

## Verification
The bench builds the slave with ADDR_W=4, DATA_W=8, WAIT_CYC=2 and two synchroniser stages. The 16 words are therefore few enough to hit both end addresses, and with two wait cycles the wait counter has to run more than one step. With these values, counting cycles between a strobe edge and acknowledge checks the synchroniser depth, the decode cycle, the wait count and the data-before-acknowledge cycle exactly. The same counts apply to a strobe swap done straight after an acknowledge and to conflicting strobes held for many cycles.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEC  = 3'd1,
    ST_WAIT = 3'd2,
    ST_RDRV = 3'd3,
    ST_RACK = 3'd4,
    ST_WACK = 3'd5,
    ST_ERR  = 3'd6
  } hs_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = chain[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= src;
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hs_regfile.sv
module hs_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic wen;
    assign wen = we_i && (addr_i == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[i] <= '0;
      else if (wen) mem[i] <= wdata_i;
    end
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
#(
  parameter int WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_s_i,
  input  logic wr_s_i,
  output logic cap_en_o,
  output logic we_o,
  output logic ld_o,
  output logic ack_o,
  output logic oe_o
);
  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = (WAIT_CYC > 0) ? CNT_W'(WAIT_CYC - 1) : '0;

  hs_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_rd_q, dir_rd_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    dir_rd_d = dir_rd_q;
    cap_en_o = 1'b0;
    we_o     = 1'b0;
    ld_o     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (rd_s_i && wr_s_i) begin
          state_d = ST_ERR;
        end else if (rd_s_i || wr_s_i) begin
          cap_en_o = 1'b1;
          dir_rd_d = rd_s_i;
          state_d  = ST_DEC;
        end
      end
      ST_DEC: begin
        if (WAIT_CYC == 0) begin
          if (dir_rd_q) begin
            ld_o    = 1'b1;
            state_d = ST_RDRV;
          end else begin
            we_o    = 1'b1;
            state_d = ST_WACK;
          end
        end else begin
          cnt_d   = CNT_LOAD;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cnt_q == '0) begin
          if (dir_rd_q) begin
            ld_o    = 1'b1;
            state_d = ST_RDRV;
          end else begin
            we_o    = 1'b1;
            state_d = ST_WACK;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RDRV: state_d = ST_RACK;
      ST_RACK: if (!rd_s_i) state_d = ST_IDLE;
      ST_WACK: if (!wr_s_i) state_d = ST_IDLE;
      ST_ERR:  if (!rd_s_i && !wr_s_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      dir_rd_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      dir_rd_q <= dir_rd_d;
    end
  end

  assign ack_o = (state_q == ST_RACK) || (state_q == ST_WACK);
  assign oe_o  = (state_q == ST_RDRV) || (state_q == ST_RACK);

  // R6
  conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && rd_s_i && wr_s_i) |=> (!ack_o && !we_o));
  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERR && (rd_s_i || wr_s_i)) |=> (state_q == ST_ERR && !ack_o));
  // R3
  data_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_o) && oe_o) |-> $past(oe_o));
  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && oe_o && rd_s_i) |=> (ack_o && oe_o));
  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !rd_s_i && !wr_s_i) |=> (!ack_o && !oe_o));
  // R7
  ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |=> !ack_o);
endmodule

// File: rtl/hs_mem_slave.sv
module hs_mem_slave #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int WAIT_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic              bus_ack
);
  logic              rst_n_sync;
  logic [1:0]        strobe_s;
  logic              cap_en, we, ld, ack, oe;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, mem_rd;

  hs_sync #(.STAGES(2), .WIDTH(1)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_n_sync)
  );

  hs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_strobe_sync (
    .clk(clk), .rst_n(rst_n_sync), .d_i({bus_rd, bus_wr}), .q_o(strobe_s)
  );

  hs_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n_sync),
    .rd_s_i(strobe_s[1]), .wr_s_i(strobe_s[0]),
    .cap_en_o(cap_en), .we_o(we), .ld_o(ld), .ack_o(ack), .oe_o(oe)
  );

  hs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .we_i(we),
    .addr_i(addr_q), .wdata_i(wdata_q), .rdata_o(mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      addr_q  <= bus_addr;
      wdata_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) rdata_q <= '0;
    else if (ld)     rdata_q <= mem_rd;
  end

  assign bus_rdata    = oe ? rdata_q : '0;
  assign bus_rdata_oe = oe;
  assign bus_ack      = ack;

  // R5
  no_oe_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (we || $past(we)) |-> !bus_rdata_oe);
endmodule

// File: tb/sim_hs_mem_slave.sv
`timescale 1ns/1ps
module sim_hs_mem_slave;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int W  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rdata_oe, bus_ack;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hs_mem_slave #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYC(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ack(bus_ack)
  );

  // op(1: write) , addr[3:0], data[7:0]; read entries carry the expected word
  localparam logic [12:0] VEC [10] = '{
    {1'b1, 4'h3, 8'hA5}, {1'b1, 4'hC, 8'h3C}, {1'b1, 4'h0, 8'h01},
    {1'b1, 4'hF, 8'hFF}, {1'b0, 4'h3, 8'hA5}, {1'b0, 4'hC, 8'h3C},
    {1'b0, 4'h0, 8'h01}, {1'b0, 4'hF, 8'hFF}, {1'b1, 4'h3, 8'h5A},
    {1'b0, 4'h3, 8'h5A}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic release_check(input string tag);
    @(negedge clk);
    @(negedge clk);
    check(bus_ack == 1'b1, {tag, " R4 ack held 2 cycles after release"}, bus_ack, 1);
    @(negedge clk);
    check(bus_ack == 1'b0, {tag, " R4 ack low 3 cycles after release"}, bus_ack, 0);
    check(bus_rdata_oe == 1'b0 && bus_rdata == '0, {tag, " R5 bus quiet after release"},
          {bus_rdata_oe, bus_rdata}, 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n = 0;
    bit saw_oe = 1'b0;
    @(negedge clk);
    bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b1;
    while (n < 60) begin
      @(negedge clk);
      n++;
      if (bus_rdata_oe) saw_oe = 1'b1;
      if (bus_ack) break;
    end
    check(n == W + 4, "R2 write ack latency", n, W + 4);
    check(!saw_oe && bus_rdata == '0, "R5 no drive during write", saw_oe, 0);
    repeat (3) @(negedge clk);
    check(bus_ack == 1'b1, "R4 write ack held with strobe", bus_ack, 1);
    bus_wr = 1'b0;
    release_check("write");
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int n = 0;
    int n_oe = 0;
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b1;
    while (n < 60) begin
      @(negedge clk);
      n++;
      if (bus_rdata_oe && n_oe == 0) n_oe = n;
      if (bus_ack) break;
    end
    check(n_oe == W + 4, "R3 read data drive latency", n_oe, W + 4);
    check(n == W + 5, "R3 read ack latency", n, W + 5);
    check(bus_rdata == exp, "R2/R3 read data", bus_rdata, exp);
    bus_rd = 1'b0;
    release_check("read");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(bus_ack == 1'b0, "R1 reset ack", bus_ack, 0);
    check(bus_rdata_oe == 1'b0, "R1 reset oe", bus_rdata_oe, 0);
    check(bus_rdata == '0, "R1 reset rdata", bus_rdata, 0);
    do_read(4'h7, 8'h00);
    do_read(4'hF, 8'h00);

    // table of write/read vectors (R2, R3)
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][12]) do_write(VEC[i][11:8], VEC[i][7:0]);
      else            do_read(VEC[i][11:8], VEC[i][7:0]);
    end

    // R6 conflicting strobes: no ack, no store, held until bus free
    begin
      bit seen = 1'b0;
      @(negedge clk);
      bus_addr = 4'h3; bus_wdata = 8'h77;
      @(negedge clk);
      bus_rd = 1'b1; bus_wr = 1'b1;
      repeat (20) begin @(negedge clk); if (bus_ack || bus_rdata_oe) seen = 1'b1; end
      bus_wr = 1'b0;
      repeat (12) begin @(negedge clk); if (bus_ack || bus_rdata_oe) seen = 1'b1; end
      check(!seen, "R6 no ack while in error", seen, 0);
      bus_rd = 1'b0;
      repeat (4) @(negedge clk);
      do_read(4'h3, 8'h5A);
    end

    // R7 swap read strobe for write strobe in one cycle
    begin
      int n = 0;
      int low_at = 0;
      @(negedge clk);
      bus_addr = 4'h9; bus_wdata = 8'h42;
      @(negedge clk);
      bus_rd = 1'b1;
      while (n < 60 && !bus_ack) begin @(negedge clk); n++; end
      bus_rd = 1'b0; bus_wr = 1'b1;
      n = 0;
      while (n < 60) begin
        @(negedge clk);
        n++;
        if (!bus_ack && low_at == 0) low_at = n;
        if (bus_ack && low_at != 0) break;
      end
      check(low_at == 3, "R7 ack low before new command", low_at, 3);
      check(n == W + 5, "R7 swapped command ack latency", n, W + 5);
      bus_wr = 1'b0;
      repeat (4) @(negedge clk);
      do_read(4'h9, 8'h42);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule